// File: doc/BRIEF.md
# Subordinate Raster Line Counter

This block keeps the raster position for a tile and sprite display controller whose frame is paced by an external video encoder. The encoder supplies horizontal and vertical sync. The block still keeps its own programmable active width, horizontal offset and frame height. From these it produces four outputs: the internal line number that the background and sprite fetch logic use, a pixel column inside the active window, a display-enable, and a one-cycle interrupt pulse when an internal line runs out of width.

The internal line and the external scanline do not have to match. An external hsync cuts the current internal line short. An internal line that ends before the hsync starts the next internal line at once, on the same physical scanline. If the programmed line length is just under the encoder's line period, every physical scanline advances the internal line count by two. Only lines of one parity are then fetched, and the low bit of the scroll start picks which parity. A line count below the encoder's frame height makes the internal frame repeat inside one output frame.

Top module: `raster_slave_timer`

## Requirements
- R1: While reset is held, and at the first sample after release, `line_num` is 0, `line_irq` is 0, and `disp_en` is 0 when `cfg_hoff` is nonzero.
- R2: The internal line length is 8*(`cfg_hoff`+`cfg_width`+1) pixel clocks. When the pixel counter reaches the end of the line with no sync edge pending, `line_num` advances by one, the pixel counter returns to 0, and `line_irq` is high for exactly the first cycle of the new line.
- R3: `disp_en` is high only while the pixel counter lies in [8*`cfg_hoff`, 8*(`cfg_hoff`+`cfg_width`+1)) and the line index within the frame is below `cfg_vlines`. While it is high, `disp_col` equals the pixel counter minus 8*`cfg_hoff`. While it is low, `disp_col` is 0. With `cfg_vlines`=0, `disp_en` never rises.
- R4: An hsync rising edge is acted on two clocks after it is sampled. It clears the pixel counter and advances `line_num` by one, even partway through the active window, and it does not raise `line_irq`. A held hsync acts only once.
- R5: After an internal line ends by width, the next internal line's pixels continue at once on the same physical scanline. With a line length of 16 and an hsync period of 20, each hsync period advances `line_num` by two.
- R6: A vsync rising edge loads `line_num` with `cfg_scroll`, clears the line index and the pixel counter, and raises no interrupt. It takes priority over a simultaneous hsync edge.
- R7: When a line ends and the line index reaches `cfg_vlines`, the internal frame restarts: `line_num` reloads `cfg_scroll`. `cfg_vlines` accepts values up to 1023, and 512 gives 512 lines before the restart.
- R8: In the two-per-scanline case, the line number at each hsync-started line keeps the parity of `cfg_scroll` bit 0.
- R9: The minimum setting (`cfg_hoff`=0, `cfg_width`=0) gives an 8-pixel line with `disp_en` held high and an interrupt every 8 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync | input | 1 | External horizontal sync, active high |
| vsync | input | 1 | External vertical sync, active high |
| cfg_hoff | input | OFS_W (6) | Window offset in 8-pixel units |
| cfg_width | input | WID_W (6) | Active width in 8-pixel units, minus one |
| cfg_vlines | input | LINE_W (10) | Internal lines per frame |
| cfg_scroll | input | LINE_W (10) | Line number loaded at frame start |
| line_num | output | LINE_W (10) | Internal line number for fetch |
| disp_col | output | HW (10) | Pixel column inside the active window |
| disp_en | output | 1 | Active-window display enable |
| line_irq | output | 1 | One-cycle pulse on a width-ended line |

## Verification
The hardest state to reach is the double advance, where an internal line ends by width and the external hsync then cuts the following internal line a few clocks later. Reaching it needs the hsync edge placed at a known pixel count. The bench does this by aligning everything to a vsync and then driving hsync on a 20-clock schedule, timed to the two-stage sync sampler, against a 16-clock internal line. It checks the skipped line numbers and their parity for both an even and an odd scroll start.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // log2 of the pixel granularity of offset and width settings
    localparam int UNIT_LOG2 = 3;

    // reason the current internal line is finishing this cycle
    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_WIDTH = 2'd1,
        END_HSYNC = 2'd2,
        END_VSYNC = 2'd3
    } end_cause_e;

endpackage

// File: rtl/raster_sync_edge.sv
module raster_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic smp_q, smp_d;
    logic dly_q, dly_d;

    always_comb begin
        smp_d = din;
        dly_d = smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            dly_q <= 1'b0;
        end else begin
            smp_q <= smp_d;
            dly_q <= dly_d;
        end
    end

    assign rise = smp_q & ~dly_q;
endmodule

// File: rtl/raster_window.sv
module raster_window #(
    parameter int OFS_W  = 6,
    parameter int WID_W  = 6,
    parameter int LINE_W = 10,
    parameter int HW     = 10
) (
    input  logic [HW-1:0]     hcnt,
    input  logic [OFS_W-1:0]  hoff,
    input  logic [WID_W-1:0]  width,
    input  logic [LINE_W-1:0] row,
    input  logic [LINE_W-1:0] vlines,
    output logic              en,
    output logic [HW-1:0]     col
);
    import raster_pkg::*;

    logic [HW-1:0] start_px;
    logic [HW-1:0] stop_px;
    logic          in_h;
    logic          in_v;

    always_comb begin
        start_px = HW'(32'(hoff) << UNIT_LOG2);
        stop_px  = HW'((32'(hoff) + 32'(width) + 1) << UNIT_LOG2);
        in_h     = (hcnt >= start_px) && (hcnt < stop_px);
        in_v     = row < vlines;
        en       = in_h && in_v;
        col      = en ? (hcnt - start_px) : '0;
    end
endmodule

// File: rtl/raster_slave_timer.sv
module raster_slave_timer #(
    parameter int OFS_W  = 6,
    parameter int WID_W  = 6,
    parameter int LINE_W = 10,
    localparam int HW    = ((OFS_W > WID_W) ? OFS_W : WID_W) + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [OFS_W-1:0]  cfg_hoff,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [LINE_W-1:0] cfg_vlines,
    input  logic [LINE_W-1:0] cfg_scroll,
    output logic [LINE_W-1:0] line_num,
    output logic [HW-1:0]     disp_col,
    output logic              disp_en,
    output logic              line_irq
);
    import raster_pkg::*;

    typedef struct packed {
        logic [HW-1:0]     hcnt;
        logic [LINE_W-1:0] row;
        logic [LINE_W-1:0] line;
        logic              irq;
    } ctr_t;

    ctr_t       st_q, st_d;
    end_cause_e cause;
    logic [1:0] sync_in;
    logic [1:0] sync_rise;
    logic       hs_rise;
    logic       vs_rise;
    logic [HW-1:0]     last_px;
    logic [LINE_W-1:0] row_inc;

    assign sync_in = {vsync, hsync};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            raster_sync_edge u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (sync_in[g]),
                .rise (sync_rise[g])
            );
        end
    endgenerate

    assign hs_rise = sync_rise[0];
    assign vs_rise = sync_rise[1];

    always_comb begin
        last_px = HW'(((32'(cfg_hoff) + 32'(cfg_width) + 1) << UNIT_LOG2) - 1);
        row_inc = st_q.row + LINE_W'(1);

        if (vs_rise)                  cause = END_VSYNC;
        else if (hs_rise)             cause = END_HSYNC;
        else if (st_q.hcnt >= last_px) cause = END_WIDTH;
        else                          cause = END_NONE;

        st_d      = st_q;
        st_d.hcnt = st_q.hcnt + HW'(1);
        st_d.irq  = 1'b0;

        unique case (cause)
            END_VSYNC: begin
                st_d.hcnt = '0;
                st_d.row  = '0;
                st_d.line = cfg_scroll;
            end
            END_HSYNC, END_WIDTH: begin
                st_d.hcnt = '0;
                st_d.irq  = (cause == END_WIDTH);
                if (row_inc == cfg_vlines) begin
                    st_d.row  = '0;
                    st_d.line = cfg_scroll;
                end else begin
                    st_d.row  = row_inc;
                    st_d.line = st_q.line + LINE_W'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    raster_window #(
        .OFS_W (OFS_W),
        .WID_W (WID_W),
        .LINE_W(LINE_W),
        .HW    (HW)
    ) u_window (
        .hcnt  (st_q.hcnt),
        .hoff  (cfg_hoff),
        .width (cfg_width),
        .row   (st_q.row),
        .vlines(cfg_vlines),
        .en    (disp_en),
        .col   (disp_col)
    );

    assign line_num = st_q.line;
    assign line_irq = st_q.irq;
endmodule

// File: rtl/raster_timer_chk.sv
module raster_timer_chk #(
    parameter int OFS_W  = 6,
    parameter int LINE_W = 10,
    parameter int HW     = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_rise,
    input logic              vs_rise,
    input logic              line_irq,
    input logic              disp_en,
    input logic [HW-1:0]     disp_col,
    input logic [LINE_W-1:0] line_num,
    input logic [LINE_W-1:0] cfg_scroll,
    input logic [OFS_W-1:0]  cfg_hoff
);
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |=> !line_irq); // R2

    AST_IRQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        line_irq |-> (line_num == $past(line_num) + LINE_W'(1)) || (line_num == cfg_scroll)); // R7

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && $past(disp_en) && !line_irq && !$past(hs_rise) && !$past(vs_rise)
         && $stable(cfg_hoff)) |-> disp_col == $past(disp_col) + HW'(1)); // R3

    AST_HSYNC_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        hs_rise |=> !line_irq); // R4

    AST_VSYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise |=> (line_num == $past(cfg_scroll)) && !line_irq); // R6
endmodule

bind raster_slave_timer raster_timer_chk #(
    .OFS_W (OFS_W),
    .LINE_W(LINE_W),
    .HW    (HW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_rise   (hs_rise),
    .vs_rise   (vs_rise),
    .line_irq  (line_irq),
    .disp_en   (disp_en),
    .disp_col  (disp_col),
    .line_num  (line_num),
    .cfg_scroll(cfg_scroll),
    .cfg_hoff  (cfg_hoff)
);

// File: tb/raster_slave_timer_bench.sv
`timescale 1ns/1ps
module raster_slave_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       vsync = 1'b0;
    logic [5:0] cfg_hoff = 6'd1;
    logic [5:0] cfg_width = 6'd1;
    logic [9:0] cfg_vlines = 10'd100;
    logic [9:0] cfg_scroll = 10'd0;
    logic [9:0] line_num;
    logic [9:0] disp_col;
    logic       disp_en;
    logic       line_irq;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    raster_slave_timer u_raster_slave_timer (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .cfg_hoff(cfg_hoff), .cfg_width(cfg_width),
        .cfg_vlines(cfg_vlines), .cfg_scroll(cfg_scroll),
        .line_num(line_num), .disp_col(disp_col),
        .disp_en(disp_en), .line_irq(line_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int hoff, input int wid, input int vl, input int scr);
        @(negedge clk);
        cfg_hoff = 6'(hoff); cfg_width = 6'(wid);
        cfg_vlines = 10'(vl); cfg_scroll = 10'(scr);
    endtask

    // returns at the first negedge where the vsync effect is visible
    task automatic pulse_vsync();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_hsync();
        @(negedge clk) hsync = 1'b1;
        @(negedge clk) hsync = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 line during reset", line_num, 0);
        chk("R1 irq during reset", line_irq, 0);
        rst_n = 1'b1;
        chk("R1 line after release", line_num, 0);
        chk("R1 irq after release", line_irq, 0);
        chk("R1 en after release", disp_en, 0);
    endtask

    task automatic t_free_run();
        set_cfg(1, 1, 100, 4);
        pulse_vsync();
        for (int k = 0; k < 50; k++) begin
            chk("R3 window enable", disp_en, (k % 24) >= 8);
            chk("R3 column", disp_col, ((k % 24) >= 8) ? (k % 24) - 8 : 0);
            chk("R2 irq pulse", line_irq, (k > 0) && (k % 24 == 0));
            chk("R2 line advance", line_num, 4 + k / 24);
            @(negedge clk);
        end
    endtask

    task automatic t_hsync_cut();
        set_cfg(1, 1, 100, 4);
        pulse_vsync();
        repeat (12) @(negedge clk);
        pulse_hsync();
        chk("R4 cut line advance", line_num, 5);
        chk("R4 cut no irq", line_irq, 0);
        chk("R4 cut counter cleared", disp_en, 0);
        repeat (8) @(negedge clk);
        chk("R4 new window start en", disp_en, 1);
        chk("R4 new window start col", disp_col, 0);
        pulse_vsync();
        @(negedge clk) hsync = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 held hsync acts once", line_num, 5);
        chk("R4 held hsync column", disp_col, 10);
        hsync = 1'b0;
    endtask

    task automatic t_double(input int scr);
        set_cfg(0, 1, 100, scr);
        pulse_vsync();
        for (int i = 0; i < 3; i++) begin
            repeat (16) @(negedge clk);
            chk("R5 early end advance", line_num, scr + 2 * i + 1);
            chk("R5 early end irq", line_irq, 1);
            chk("R5 pixels continue en", disp_en, 1);
            chk("R5 pixels continue col", disp_col, 0);
            repeat (2) @(negedge clk);
            hsync = 1'b1;
            @(negedge clk) hsync = 1'b0;
            @(negedge clk);
            chk("R5 second advance", line_num, scr + 2 * i + 2);
            chk("R5 hsync no irq", line_irq, 0);
            chk("R8 parity kept", line_num % 2, scr % 2);
        end
    endtask

    task automatic t_restart();
        set_cfg(1, 1, 3, 10);
        pulse_vsync();
        repeat (24) @(negedge clk);
        chk("R7 line 1", line_num, 11);
        repeat (24) @(negedge clk);
        chk("R7 line 2", line_num, 12);
        repeat (24) @(negedge clk);
        chk("R7 restart reload", line_num, 10);
        chk("R7 restart irq", line_irq, 1);
    endtask

    task automatic t_tall();
        set_cfg(0, 0, 512, 0);
        pulse_vsync();
        repeat (8 * 511) @(negedge clk);
        chk("R7 512 last line", line_num, 511);
        repeat (8) @(negedge clk);
        chk("R7 512 restart", line_num, 0);
    endtask

    task automatic t_min();
        set_cfg(0, 0, 100, 0);
        pulse_vsync();
        for (int k = 0; k < 17; k++) begin
            chk("R9 en high", disp_en, 1);
            chk("R9 column", disp_col, k % 8);
            chk("R9 irq every 8", line_irq, (k > 0) && (k % 8 == 0));
            @(negedge clk);
        end
    endtask

    task automatic t_vsync_mid();
        set_cfg(1, 1, 100, 20);
        pulse_vsync();
        repeat (30) @(negedge clk);
        chk("R6 before reload", line_num, 21);
        pulse_vsync();
        chk("R6 reload", line_num, 20);
        chk("R6 no irq", line_irq, 0);
        chk("R6 counter cleared", disp_en, 0);
        repeat (8) @(negedge clk);
        chk("R6 window restart", disp_col + 100 * disp_en, 100);
        repeat (30) @(negedge clk);
        @(negedge clk) begin hsync = 1'b1; vsync = 1'b1; end
        @(negedge clk) begin hsync = 1'b0; vsync = 1'b0; end
        @(negedge clk);
        chk("R6 priority over hsync", line_num, 20);
    endtask

    task automatic t_vzero();
        set_cfg(1, 1, 0, 0);
        pulse_vsync();
        repeat (10) @(negedge clk);
        chk("R3 zero lines en", disp_en, 0);
        chk("R3 zero lines col", disp_col, 0);
    endtask

    initial begin
        t_reset();
        t_free_run();
        t_hsync_cut();
        t_double(6);
        t_double(7);
        t_restart();
        t_tall();
        t_min();
        t_vsync_mid();
        t_vzero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule